// File: doc/BRIEF.md
# Memory Protection Rule Table

This block screens every transaction headed for a memory controller. It keeps a table of twenty access rules, each describing a window of 1 MiB address pages, a window of transaction IDs, which requester ports it applies to, which security states it applies to, and whether a hit grants or refuses the access. A request is compared against all twenty rules at once. The lowest-numbered rule that matches decides the outcome. If no rule matches, a per-port default bit decides.

Software never addresses a rule directly. It fills three staging registers (page window, ID window, attributes) and then writes a command register. The command holds a rule index and one of two strobes. One strobe copies the staging registers into the chosen rule. The other copies the chosen rule back into the staging registers so that software can read it.

The verdict is registered. It appears one clock after the request.

Top module: `memprot_table`

## Requirements
- R1: After reset every rule is invalid, the default register is 0, and every readable register reads 0. A request from any port 0 to 9 is therefore allowed.
- R2: `rsp_valid` is high in exactly the cycles that follow a cycle with `req_valid` high. `rsp_allow` is 0 whenever `rsp_valid` is 0.
- R3: A rule matches only when all of these hold:
  - its port-mask bit for `req_port` is set;
  - its low ID ≤ `req_id` ≤ its high ID;
  - its low page ≤ `req_addr[31:20]` ≤ its high page;
  - its security field accepts the request: field bit 0 accepts secure requests and field bit 1 accepts non-secure requests.
- R4: When several rules match, the lowest-numbered one decides. A result bit of 0 grants access and a result bit of 1 denies it.
- R5: When no valid rule matches, the request is denied if the default-register bit for its port is 1, and allowed if that bit is 0.
- R6: Requests from ports 10 to 15 are always denied.
- R7: The register select codes and field layouts are as follows. Bits not listed read as 0. Selects 5 to 7 read 0 and ignore writes.

  | Select | Register | Fields |
  |---|---|---|
  | 0 | command | rule index in bits 4:0, commit strobe in bit 5, fetch strobe in bit 6 |
  | 1 | page window | low page in bits 11:0, high page in bits 23:12 |
  | 2 | ID window | low ID in bits 11:0, high ID in bits 23:12 |
  | 3 | attributes | security in bits 1:0, valid in bit 2, port mask in bits 12:3, result in bit 13 |
  | 4 | default | per-port default in bits 9:0 |

- R8: A command write with the commit strobe copies the staging registers into the indexed rule. A request presented in the very next cycle is judged by the new rule.
- R9: A command write with the fetch strobe loads the indexed rule into the staging registers. The values can be read back from the next cycle on.
- R10: A command write with neither strobe set, or with an index of 20 or more, changes no rule and no staging register.
- R11: A command write with both strobes set performs the commit only.
- R12: A rule whose valid bit is 0 never matches, whatever its other fields hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write enable |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data of the selected register (combinational) |
| req_valid | input | 1 | Request present |
| req_port | input | 4 | Requesting port number |
| req_id | input | 12 | Transaction ID |
| req_secure | input | 1 | 1 for a secure request, 0 for a non-secure request |
| req_addr | input | 32 | Byte address |
| rsp_valid | output | 1 | Verdict present (one cycle after the request) |
| rsp_allow | output | 1 | 1 = grant, 0 = deny |

## Verification
The properties assume that the select, write-enable and request inputs carry known values on every clock edge once reset is released. They also assume that a register write lasts a single cycle with its data held steady across that edge. The stimulus meets these assumptions in three ways:
- it drives every input from time zero;
- it changes inputs only on the falling clock edge;
- it lowers the write enable one cycle after raising it.

Requests are likewise held for exactly one cycle, and the verdict is read on the following falling edge.

// File: rtl/memprot_pkg.sv
package memprot_pkg;
    localparam int MP_REG_W      = 32;
    localparam int MP_SEL_W      = 3;
    localparam int MP_FIELD_W    = 12;
    localparam int MP_PORTS      = 10;
    localparam int MP_PORT_IDX_W = 4;
    localparam int MP_PORT_SPAN  = 1 << MP_PORT_IDX_W;
    localparam int MP_IDX_W      = 5;
    localparam int MP_COMMIT_BIT = 5;
    localparam int MP_FETCH_BIT  = 6;
    localparam int MP_SEC_W      = 2;
    localparam int MP_VALID_BIT  = 2;
    localparam int MP_PORTS_LSB  = 3;
    localparam int MP_RESULT_BIT = MP_PORTS_LSB + MP_PORTS;
    localparam int MP_ATTR_W     = MP_RESULT_BIT + 1;
    localparam int MP_WIN_W      = 2 * MP_FIELD_W;

    typedef enum logic [MP_SEL_W-1:0] {
        SEL_CMD   = 3'd0,
        SEL_PAGES = 3'd1,
        SEL_IDS   = 3'd2,
        SEL_ATTR  = 3'd3,
        SEL_DFLT  = 3'd4
    } cfg_sel_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_COMMIT,
        OP_FETCH
    } cmd_op_e;

    typedef struct packed {
        logic [MP_FIELD_W-1:0] hi_page;
        logic [MP_FIELD_W-1:0] lo_page;
        logic [MP_FIELD_W-1:0] hi_id;
        logic [MP_FIELD_W-1:0] lo_id;
        logic                  deny;
        logic [MP_PORTS-1:0]   ports;
        logic                  valid;
        logic [MP_SEC_W-1:0]   sec;
    } rule_t;
endpackage

// File: rtl/memprot_rule_match.sv
module memprot_rule_match
    import memprot_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int PAGE_SHIFT = 20
) (
    input  rule_t                    entry,
    input  logic [MP_PORT_IDX_W-1:0] port,
    input  logic [MP_FIELD_W-1:0]    id,
    input  logic                     secure,
    input  logic [ADDR_W-1:0]        addr,
    output logic                     hit
);
    logic [MP_FIELD_W-1:0]   page;
    logic [MP_PORT_SPAN-1:0] port_map;
    logic                    port_ok, id_ok, page_ok, sec_ok;

    always_comb begin
        page     = MP_FIELD_W'(addr >> PAGE_SHIFT);
        port_map = MP_PORT_SPAN'(entry.ports);
        port_ok  = port_map[port];
        id_ok    = (id >= entry.lo_id) && (id <= entry.hi_id);
        page_ok  = (page >= entry.lo_page) && (page <= entry.hi_page);
        sec_ok   = secure ? entry.sec[0] : entry.sec[1];
        hit      = entry.valid && port_ok && id_ok && page_ok && sec_ok;
    end
endmodule

// File: rtl/memprot_first_hit.sv
module memprot_first_hit #(
    parameter int N = 20
) (
    input  logic [N-1:0] hit,
    input  logic [N-1:0] deny,
    output logic         any_hit,
    output logic         win_deny
);
    always_comb begin
        any_hit  = 1'b0;
        win_deny = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit[i]) begin
                any_hit  = 1'b1;
                win_deny = deny[i];
            end
        end
    end
endmodule

// File: rtl/memprot_table.sv
module memprot_table
    import memprot_pkg::*;
#(
    parameter int NUM_RULES  = 20,
    parameter int ADDR_W     = 32,
    parameter int PAGE_SHIFT = 20
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [MP_SEL_W-1:0]      cfg_sel,
    input  logic [MP_REG_W-1:0]      cfg_wdata,
    output logic [MP_REG_W-1:0]      cfg_rdata,
    input  logic                     req_valid,
    input  logic [MP_PORT_IDX_W-1:0] req_port,
    input  logic [MP_FIELD_W-1:0]    req_id,
    input  logic                     req_secure,
    input  logic [ADDR_W-1:0]        req_addr,
    output logic                     rsp_valid,
    output logic                     rsp_allow
);
    logic [MP_IDX_W-1:0]        sel_idx_q;
    logic [MP_WIN_W-1:0]        pages_q;
    logic [MP_WIN_W-1:0]        ids_q;
    logic [MP_ATTR_W-1:0]       attr_q;
    logic [MP_PORTS-1:0]        dflt_q;
    rule_t [NUM_RULES-1:0]      rule_vec;
    rule_t                      staged;
    rule_t                      fetched;
    logic [NUM_RULES-1:0]       hit_vec;
    logic [NUM_RULES-1:0]       deny_vec;
    logic [MP_IDX_W-1:0]        op_idx;
    cmd_op_e                    op;
    logic                       any_hit, win_deny, allow_c;
    logic [MP_PORT_SPAN-1:0]    dflt_ext;

    // staging registers viewed as one rule
    always_comb begin
        staged.lo_page = pages_q[MP_FIELD_W-1:0];
        staged.hi_page = pages_q[MP_WIN_W-1:MP_FIELD_W];
        staged.lo_id   = ids_q[MP_FIELD_W-1:0];
        staged.hi_id   = ids_q[MP_WIN_W-1:MP_FIELD_W];
        staged.sec     = attr_q[MP_SEC_W-1:0];
        staged.valid   = attr_q[MP_VALID_BIT];
        staged.ports   = attr_q[MP_PORTS_LSB +: MP_PORTS];
        staged.deny    = attr_q[MP_RESULT_BIT];
    end

    // command decode: commit outranks fetch, out-of-range index is a no-op
    always_comb begin
        op_idx = cfg_wdata[MP_IDX_W-1:0];
        op     = OP_NONE;
        if (cfg_we && cfg_sel == SEL_CMD && int'(op_idx) < NUM_RULES) begin
            if (cfg_wdata[MP_COMMIT_BIT])
                op = OP_COMMIT;
            else if (cfg_wdata[MP_FETCH_BIT])
                op = OP_FETCH;
        end
    end

    always_comb begin
        fetched = '0;
        for (int i = 0; i < NUM_RULES; i++)
            if (int'(op_idx) == i)
                fetched = rule_vec[i];
    end

    // register file writes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_idx_q <= '0;
            pages_q   <= '0;
            ids_q     <= '0;
            attr_q    <= '0;
            dflt_q    <= '0;
        end else if (cfg_we) begin
            case (cfg_sel)
                SEL_CMD: begin
                    sel_idx_q <= op_idx;
                    if (op == OP_FETCH) begin
                        pages_q <= {fetched.hi_page, fetched.lo_page};
                        ids_q   <= {fetched.hi_id, fetched.lo_id};
                        attr_q  <= {fetched.deny, fetched.ports, fetched.valid, fetched.sec};
                    end
                end
                SEL_PAGES: pages_q <= cfg_wdata[MP_WIN_W-1:0];
                SEL_IDS:   ids_q   <= cfg_wdata[MP_WIN_W-1:0];
                SEL_ATTR:  attr_q  <= cfg_wdata[MP_ATTR_W-1:0];
                SEL_DFLT:  dflt_q  <= cfg_wdata[MP_PORTS-1:0];
                default: ;
            endcase
        end
    end

    // rule storage and per-rule comparators
    for (genvar g = 0; g < NUM_RULES; g++) begin : g_rule
        rule_t entry_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                entry_q <= '0;
            else if (op == OP_COMMIT && op_idx == MP_IDX_W'(g))
                entry_q <= staged;
        end
        assign rule_vec[g] = entry_q;
        assign deny_vec[g] = entry_q.deny;

        memprot_rule_match #(
            .ADDR_W    (ADDR_W),
            .PAGE_SHIFT(PAGE_SHIFT)
        ) u_match (
            .entry (entry_q),
            .port  (req_port),
            .id    (req_id),
            .secure(req_secure),
            .addr  (req_addr),
            .hit   (hit_vec[g])
        );
    end

    memprot_first_hit #(.N(NUM_RULES)) u_pick (
        .hit     (hit_vec),
        .deny    (deny_vec),
        .any_hit (any_hit),
        .win_deny(win_deny)
    );

    always_comb begin
        dflt_ext = MP_PORT_SPAN'(dflt_q);
        if (int'(req_port) >= MP_PORTS)
            allow_c = 1'b0;
        else if (any_hit)
            allow_c = !win_deny;
        else
            allow_c = !dflt_ext[req_port];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_allow <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            rsp_allow <= req_valid && allow_c;
        end
    end

    always_comb begin
        case (cfg_sel)
            SEL_CMD:   cfg_rdata = MP_REG_W'(sel_idx_q);
            SEL_PAGES: cfg_rdata = MP_REG_W'(pages_q);
            SEL_IDS:   cfg_rdata = MP_REG_W'(ids_q);
            SEL_ATTR:  cfg_rdata = MP_REG_W'(attr_q);
            SEL_DFLT:  cfg_rdata = MP_REG_W'(dflt_q);
            default:   cfg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/memprot_table_chk.sv
module memprot_table_chk
    import memprot_pkg::*;
(
    input logic                     clk,
    input logic                     rst_n,
    input logic                     cfg_we,
    input logic [MP_SEL_W-1:0]      cfg_sel,
    input logic [MP_REG_W-1:0]      cfg_rdata,
    input logic                     req_valid,
    input logic [MP_PORT_IDX_W-1:0] req_port,
    input logic                     rsp_valid,
    input logic                     rsp_allow,
    input logic [MP_PORTS-1:0]      dflt_q
);
    // R2
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R2
    rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !rsp_allow));

    // R6
    foreign_port_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && int'(req_port) >= MP_PORTS) |=> !rsp_allow);

    // R7
    dflt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_we && cfg_sel == SEL_DFLT) |=> $stable(dflt_q));

    // R7
    spare_sel_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_sel > SEL_DFLT) |-> (cfg_rdata == '0));

    // R7
    window_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_sel == SEL_PAGES || cfg_sel == SEL_IDS) |-> (cfg_rdata[MP_REG_W-1:MP_WIN_W] == '0));
endmodule

bind memprot_table memprot_table_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_sel  (cfg_sel),
    .cfg_rdata(cfg_rdata),
    .req_valid(req_valid),
    .req_port (req_port),
    .rsp_valid(rsp_valid),
    .rsp_allow(rsp_allow),
    .dflt_q   (dflt_q)
);

// File: tb/memprot_table_test.sv
module memprot_table_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic [3:0]  req_port = '0;
    logic [11:0] req_id = '0;
    logic        req_secure = 1'b0;
    logic [31:0] req_addr = '0;
    logic        rsp_valid, rsp_allow;
    int          total = 0;
    int          bad = 0;

    always #10 clk = ~clk;

    memprot_table uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
        .req_port(req_port), .req_id(req_id), .req_secure(req_secure),
        .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_allow(rsp_allow)
    );

    // {port[49:46], id[45:34], secure[33], addr[32:1], expected allow[0]}
    localparam logic [49:0] VEC [0:13] = '{
        {4'd3, 12'h005, 1'b1, 32'h0000_0000, 1'b1},
        {4'd9, 12'hFFF, 1'b0, 32'h0FF0_0000, 1'b1},
        {4'd2, 12'h015, 1'b1, 32'h1000_0000, 1'b0},
        {4'd2, 12'h015, 1'b0, 32'h1000_0000, 1'b1},
        {4'd3, 12'h015, 1'b1, 32'h1800_0000, 1'b1},
        {4'd2, 12'h020, 1'b1, 32'h1FF0_0000, 1'b1},
        {4'd2, 12'h00F, 1'b1, 32'h1000_0000, 1'b1},
        {4'd2, 12'h010, 1'b1, 32'h1FFF_FFFF, 1'b0},
        {4'd4, 12'h000, 1'b0, 32'h2000_0000, 1'b0},
        {4'd4, 12'h000, 1'b1, 32'h2000_0000, 1'b1},
        {4'd0, 12'h000, 1'b1, 32'h2010_0000, 1'b0},
        {4'd1, 12'h007, 1'b0, 32'hFFF0_0000, 1'b0},
        {4'd7, 12'h007, 1'b0, 32'hFFF0_0000, 1'b1},
        {4'd12, 12'h000, 1'b1, 32'h0000_0000, 1'b0}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [2:0] sel, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_read(input logic [2:0] sel, output logic [31:0] data);
        @(negedge clk);
        cfg_sel = sel;
        #1 data = cfg_rdata;
    endtask

    task automatic stage(input logic [11:0] lo_pg, hi_pg, lo_id, hi_id,
                         input logic [1:0] sec, input logic valid,
                         input logic [9:0] ports, input logic deny);
        cfg_write(3'd1, {8'h0, hi_pg, lo_pg});
        cfg_write(3'd2, {8'h0, hi_id, lo_id});
        cfg_write(3'd3, {18'h0, deny, ports, valid, sec});
    endtask

    task automatic commit(input int idx);
        cfg_write(3'd0, 32'(idx) | 32'h20);
    endtask

    task automatic request(input logic [3:0] port, input logic [11:0] id,
                           input logic sec, input logic [31:0] addr,
                           output logic vld, output logic allow);
        @(negedge clk);
        req_valid = 1'b1; req_port = port; req_id = id; req_secure = sec; req_addr = addr;
        @(negedge clk);
        vld = rsp_valid; allow = rsp_allow;
        req_valid = 1'b0;
    endtask

    task automatic finish_run;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        logic v, a;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int s = 0; s < 5; s++) begin
            cfg_read(3'(s), rd);
            check("R1 register clear", rd, 32'h0);
        end
        check("R2 no response while idle", {31'h0, rsp_valid}, 32'h0);
        request(4'd0, 12'h0, 1'b1, 32'h5000_0000, v, a);
        check("R2 response valid", {31'h0, v}, 32'h1);
        check("R1 empty table allows", {31'h0, a}, 32'h1);
        @(negedge clk);
        check("R2 response drops", {31'h0, rsp_valid}, 32'h0);

        // rule set for the vector walk
        stage(12'h000, 12'h0FF, 12'h000, 12'hFFF, 2'd3, 1'b1, 10'h3FF, 1'b0); commit(0);
        stage(12'h100, 12'h1FF, 12'h010, 12'h01F, 2'd1, 1'b1, 10'h004, 1'b1); commit(2);
        stage(12'h100, 12'h1FF, 12'h000, 12'hFFF, 2'd3, 1'b1, 10'h3FF, 1'b0); commit(5);
        stage(12'h200, 12'h200, 12'h000, 12'hFFF, 2'd2, 1'b1, 10'h3FF, 1'b1); commit(19);
        cfg_write(3'd4, 32'h0000_0003);

        // R3 R4 R5 R6 vector walk
        for (int i = 0; i < 14; i++) begin
            request(VEC[i][49:46], VEC[i][45:34], VEC[i][33], VEC[i][32:1], v, a);
            check($sformatf("R3/R4/R5/R6 vector %0d", i), {31'h0, a}, {31'h0, VEC[i][0]});
        end

        // R9 fetch rule 2
        cfg_write(3'd0, 32'h0000_0042);
        cfg_read(3'd1, rd); check("R9 fetched pages", rd, 32'h001F_F100);
        cfg_read(3'd2, rd); check("R9 fetched ids", rd, 32'h0001_F010);
        cfg_read(3'd3, rd); check("R9 fetched attr", rd, 32'h0000_2025);
        cfg_read(3'd0, rd); check("R7 command index", rd, 32'h0000_0002);

        // R10 no-op commands
        cfg_write(3'd1, 32'h00AB_C123);
        cfg_write(3'd0, 32'h0000_0000);
        cfg_read(3'd1, rd); check("R10 strobe-free command", rd, 32'h00AB_C123);
        cfg_write(3'd0, 32'h0000_0054);
        cfg_read(3'd1, rd); check("R10 fetch index 20", rd, 32'h00AB_C123);
        stage(12'h000, 12'hFFF, 12'h000, 12'hFFF, 2'd3, 1'b1, 10'h3FF, 1'b1);
        cfg_write(3'd0, 32'h0000_0034);
        cfg_write(3'd0, 32'h0000_003F);
        request(4'd3, 12'h005, 1'b1, 32'h0000_0000, v, a);
        check("R10 commit index 20/31 ignored", {31'h0, a}, 32'h1);

        // R8 commit visible to the next-cycle request
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 3'd0; cfg_wdata = 32'h0000_0020;
        @(negedge clk);
        cfg_we = 1'b0;
        req_valid = 1'b1; req_port = 4'd3; req_id = 12'h005; req_secure = 1'b1; req_addr = '0;
        @(negedge clk);
        req_valid = 1'b0;
        check("R8 new rule decides next cycle", {31'h0, rsp_allow}, 32'h0);

        // R11 both strobes: commit only
        stage(12'h000, 12'hFFF, 12'h000, 12'hFFF, 2'd3, 1'b1, 10'h3FF, 1'b0);
        cfg_write(3'd0, 32'h0000_0060);
        request(4'd3, 12'h005, 1'b1, 32'h0000_0000, v, a);
        check("R11 dual strobe commits", {31'h0, a}, 32'h1);

        // R12 invalid rule ignored
        stage(12'h000, 12'hFFF, 12'h000, 12'hFFF, 2'd3, 1'b0, 10'h3FF, 1'b1);
        commit(0);
        request(4'd3, 12'h005, 1'b1, 32'h0000_0000, v, a);
        check("R12 invalid rule skipped", {31'h0, a}, 32'h1);

        // R7 layouts and spare selects
        cfg_write(3'd5, 32'hFFFF_FFFF);
        cfg_read(3'd5, rd); check("R7 spare select reads zero", rd, 32'h0);
        cfg_read(3'd4, rd); check("R7 default untouched", rd, 32'h0000_0003);
        cfg_write(3'd3, 32'hFFFF_FFFF);
        cfg_read(3'd3, rd); check("R7 attr width", rd, 32'h0000_3FFF);
        cfg_write(3'd4, 32'hFFFF_FFFF);
        cfg_read(3'd4, rd); check("R7 default width", rd, 32'h0000_03FF);
        cfg_read(3'd7, rd); check("R7 select 7 reads zero", rd, 32'h0);

        // R1 reset mid-run clears rules and default
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        request(4'd2, 12'h015, 1'b1, 32'h1000_0000, v, a);
        check("R1 rules cleared by reset", {31'h0, a}, 32'h1);
        cfg_read(3'd4, rd); check("R1 default cleared", rd, 32'h0);

        finish_run();
    end
endmodule